// File: doc/BRIEF.md
# Time-Multiplexed Pairwise Interaction Engine

This engine keeps a group of target items resident and sums, for each of them, an interaction with every source item in a stream. It has six physical lanes. Each lane owns eight target slots and uses one shared multiply-accumulate datapath for all of them. The lane visits its slots in turn, one slot per clock. A source record is taken in once, held, and applied to all 48 resident targets across one eight-cycle rotation before the next record enters. The engine therefore fetches one record per 48 interactions instead of one per interaction.

In a larger system, many copies of the engine hold the same 48 targets, and each copy sees a different part of the source population. Their partial sums are added outside the block.

The interaction is a signed fixed-point product, not real physics. Each target names one 16-bit word of the 512-bit source record. The engine multiplies that word by the target's signed coefficient and adds the product into the slot's 32-bit accumulator. A typical run is: clear, load targets, stream records, signal end of stream, wait for done, then read the 48 sums out in order.

Top module: `pairEngine`

## Requirements
- R1: After reset, `srcReady` is 1, `done` is 0, the read pointer is at lane 0 slot 0, and `rdData` is 0.
- R2: A target write (`tgtWrEn`) stores `tgtData` into lane `tgtPipe`, slot `tgtSlot`, and touches no other slot. A write with `tgtPipe` of 6 or 7 has no effect. Targets are written only while no rotation is in progress.
- R3: A record is accepted on a clock edge where `srcValid` and `srcReady` are both 1. After an acceptance, `srcReady` stays 0 for the next seven cycles. With records always offered, acceptances are exactly 8 cycles apart.
- R4: Each accepted record adds coef × word into every slot's accumulator. Here coef is the signed value of `tgtData[15:0]` and word is the signed 16-bit record word `srcRecord[16k+15:16k]`, with k = `tgtData[20:16]`.
- R5: Every accepted record reaches all 48 slots, in all six lanes, exactly once.
- R6: `clearAcc` zeroes all accumulators, drops `done`, drops any pending end of stream, aborts an open rotation and returns the read pointer to lane 0 slot 0. It takes priority over every other input. Targets are kept.
- R7: After an `eosReq` pulse, `srcReady` is 0 and no further record is accepted. Once the in-flight rotation ends, `done` rises and then stays at 1 until the next clear.
- R8: While `done` is 1, each `rdAdvance` moves the read pointer to the next slot in lane-major, slot-minor order (lane 0 slot 0 first) and wraps after lane 5 slot 7. `rdPipe` and `rdSlot` show the pointer, and `rdData` shows that slot's sum. `rdAdvance` has no effect while `done` is 0.
- R9: Accumulators wrap modulo 2^32 in two's complement.
- R10: Only the record word selected by a target enters its product. The target's selector can address any of the 32 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| clearAcc | input | 1 | Zero accumulators and restart a run |
| tgtWrEn | input | 1 | Target write strobe |
| tgtPipe | input | 3 | Target lane index |
| tgtSlot | input | 3 | Target slot index |
| tgtData | input | 21 | {word select[4:0], signed coefficient[15:0]} |
| srcValid | input | 1 | Source record offered |
| srcReady | output | 1 | Engine will take the offered record this cycle |
| srcRecord | input | 512 | Source record, 32 words of 16 bits |
| eosReq | input | 1 | End-of-stream pulse |
| done | output | 1 | All accepted records applied, sums readable |
| rdAdvance | input | 1 | Step the read pointer |
| rdPipe | output | 3 | Lane of the slot being read |
| rdSlot | output | 3 | Slot being read |
| rdData | output | 32 | Accumulated sum of that slot |

## Verification
The assertions assume four things about the inputs. `rstN` is asserted at start. `srcRecord` holds steady while offered. Target writes happen only between rotations. `rdAdvance` is meaningful only after `done` rises.

The stimulus meets these assumptions as follows. It loads targets only before streaming or after a drain. It changes records only after an acceptance has been seen. It reads the sums only after waiting for `done`. The single `rdAdvance` it sends early is there on purpose, to show that the pointer ignores it.

// File: rtl/pairEnginePkg.sv
package pairEnginePkg;
  localparam int NUM_PIPES = 6;
  localparam int NUM_SLOTS = 8;
  localparam int FIELD_W   = 16;
  localparam int REC_BYTES = 64;
  localparam int ACC_W     = 32;
  localparam int REC_W     = REC_BYTES * 8;
  localparam int NUM_WORDS = REC_W / FIELD_W;
  localparam int SEL_W     = $clog2(NUM_WORDS);
  localparam int TGT_W     = SEL_W + FIELD_W;
  localparam int PROD_W    = 2 * FIELD_W;
  localparam int PIPE_W    = $clog2(NUM_PIPES);
  localparam int SLOT_W    = $clog2(NUM_SLOTS);

  typedef struct packed {
    logic              clearAll;
    logic              latchRec;
    logic              compute;
    logic [SLOT_W-1:0] slotIdx;
  } ctrlStrobe_t;
endpackage

// File: rtl/pairEngineCtrl.sv
module pairEngineCtrl
  import pairEnginePkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clearAcc,
  input  logic              srcValid,
  input  logic              eosReq,
  input  logic              rdAdvance,
  output logic              srcReady,
  output logic              done,
  output logic [PIPE_W-1:0] rdPipe,
  output logic [SLOT_W-1:0] rdSlot,
  output ctrlStrobe_t       stb
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);
  localparam logic [PIPE_W-1:0] LAST_PIPE = PIPE_W'(NUM_PIPES - 1);

  logic              busy;
  logic [SLOT_W-1:0] slotCnt;
  logic              eosPending;
  logic              accept;

  assign srcReady = !eosPending && !done && (!busy || slotCnt == LAST_SLOT);
  assign accept   = srcValid && srcReady;

  always_ff @(posedge clk) begin
    if (!rstN || clearAcc) begin
      busy       <= 1'b0;
      slotCnt    <= '0;
      eosPending <= 1'b0;
      done       <= 1'b0;
      rdPipe     <= '0;
      rdSlot     <= '0;
    end else begin
      if (accept) begin
        busy    <= 1'b1;
        slotCnt <= '0;
      end else if (busy) begin
        if (slotCnt == LAST_SLOT) begin
          busy    <= 1'b0;
          slotCnt <= '0;
        end else begin
          slotCnt <= slotCnt + 1'b1;
        end
      end
      if (eosReq) eosPending <= 1'b1;
      if (eosPending && !busy) done <= 1'b1;
      if (done && rdAdvance) begin
        if (rdSlot == LAST_SLOT) begin
          rdSlot <= '0;
          rdPipe <= (rdPipe == LAST_PIPE) ? '0 : rdPipe + 1'b1;
        end else begin
          rdSlot <= rdSlot + 1'b1;
        end
      end
    end
  end

  always_comb begin
    stb.clearAll = clearAcc;
    stb.latchRec = accept && !clearAcc;
    stb.compute  = busy && !clearAcc;
    stb.slotIdx  = slotCnt;
  end
endmodule

// File: rtl/pairEngineLane.sv
module pairEngineLane
  import pairEnginePkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       clearAll,
  input  logic                       compute,
  input  logic [SLOT_W-1:0]          slotIdx,
  input  logic [REC_W-1:0]           recQ,
  input  logic                       wrEn,
  input  logic [SLOT_W-1:0]          wrSlot,
  input  logic [TGT_W-1:0]           wrData,
  output logic [NUM_SLOTS*ACC_W-1:0] accBus
);
  logic [TGT_W-1:0]          tgtQ [NUM_SLOTS];
  logic signed [ACC_W-1:0]   accQ [NUM_SLOTS];
  logic [TGT_W-1:0]          curTgt;
  logic [SEL_W-1:0]          curSel;
  logic signed [FIELD_W-1:0] curCoef;
  logic signed [FIELD_W-1:0] curWord;
  logic signed [PROD_W-1:0]  prod;

  assign curTgt  = tgtQ[slotIdx];
  assign curSel  = curTgt[TGT_W-1 -: SEL_W];
  assign curCoef = signed'(curTgt[FIELD_W-1:0]);
  assign curWord = signed'(recQ[curSel*FIELD_W +: FIELD_W]);
  assign prod    = curCoef * curWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SLOTS; s++) tgtQ[s] <= '0;
    end else if (wrEn) begin
      tgtQ[wrSlot] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || clearAll) begin
      for (int s = 0; s < NUM_SLOTS; s++) accQ[s] <= '0;
    end else if (compute) begin
      accQ[slotIdx] <= accQ[slotIdx] + ACC_W'(prod);
    end
  end

  always_comb begin
    for (int s = 0; s < NUM_SLOTS; s++) accBus[s*ACC_W +: ACC_W] = accQ[s];
  end
endmodule

// File: rtl/pairEngineDatapath.sv
module pairEngineDatapath
  import pairEnginePkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic [REC_W-1:0]  srcRecord,
  input  logic              tgtWrEn,
  input  logic [PIPE_W-1:0] tgtPipe,
  input  logic [SLOT_W-1:0] tgtSlot,
  input  logic [TGT_W-1:0]  tgtData,
  input  logic [PIPE_W-1:0] rdPipe,
  input  logic [SLOT_W-1:0] rdSlot,
  output logic [ACC_W-1:0]  rdData
);
  logic [REC_W-1:0]           recQ;
  logic [NUM_SLOTS*ACC_W-1:0] accBus [NUM_PIPES];

  always_ff @(posedge clk) begin
    if (!rstN)             recQ <= '0;
    else if (stb.latchRec) recQ <= srcRecord;
  end

  for (genvar p = 0; p < NUM_PIPES; p++) begin : gLane
    pairEngineLane u_lane (
      .clk      (clk),
      .rstN     (rstN),
      .clearAll (stb.clearAll),
      .compute  (stb.compute),
      .slotIdx  (stb.slotIdx),
      .recQ     (recQ),
      .wrEn     (tgtWrEn && tgtPipe == PIPE_W'(p)),
      .wrSlot   (tgtSlot),
      .wrData   (tgtData),
      .accBus   (accBus[p])
    );
  end

  assign rdData = accBus[rdPipe][rdSlot*ACC_W +: ACC_W];
endmodule

// File: rtl/pairEngine.sv
module pairEngine
  import pairEnginePkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clearAcc,
  input  logic              tgtWrEn,
  input  logic [PIPE_W-1:0] tgtPipe,
  input  logic [SLOT_W-1:0] tgtSlot,
  input  logic [TGT_W-1:0]  tgtData,
  input  logic              srcValid,
  output logic              srcReady,
  input  logic [REC_W-1:0]  srcRecord,
  input  logic              eosReq,
  output logic              done,
  input  logic              rdAdvance,
  output logic [PIPE_W-1:0] rdPipe,
  output logic [SLOT_W-1:0] rdSlot,
  output logic [ACC_W-1:0]  rdData
);
  ctrlStrobe_t stb;

  pairEngineCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .clearAcc  (clearAcc),
    .srcValid  (srcValid),
    .eosReq    (eosReq),
    .rdAdvance (rdAdvance),
    .srcReady  (srcReady),
    .done      (done),
    .rdPipe    (rdPipe),
    .rdSlot    (rdSlot),
    .stb       (stb)
  );

  pairEngineDatapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .srcRecord (srcRecord),
    .tgtWrEn   (tgtWrEn),
    .tgtPipe   (tgtPipe),
    .tgtSlot   (tgtSlot),
    .tgtData   (tgtData),
    .rdPipe    (rdPipe),
    .rdSlot    (rdSlot),
    .rdData    (rdData)
  );
endmodule

// File: rtl/pairEngineChk.sv
module pairEngineChk
  import pairEnginePkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              clearAcc,
  input logic              srcValid,
  input logic              srcReady,
  input logic              done,
  input logic              rdAdvance,
  input logic [PIPE_W-1:0] rdPipe,
  input logic [SLOT_W-1:0] rdSlot,
  input logic [ACC_W-1:0]  rdData
);
  localparam int CNT_W = $clog2(NUM_SLOTS + 1);
  logic [CNT_W-1:0] sinceAcc;

  always_ff @(posedge clk) begin
    if (!rstN || clearAcc)              sinceAcc <= CNT_W'(NUM_SLOTS);
    else if (srcValid && srcReady)      sinceAcc <= '0;
    else if (sinceAcc < CNT_W'(NUM_SLOTS)) sinceAcc <= sinceAcc + 1'b1;
  end

  AST_READY_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    srcReady |-> sinceAcc >= CNT_W'(NUM_SLOTS - 1)); // R3

  AST_NO_ACCEPT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !srcReady); // R7

  AST_CLEAR_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    clearAcc |=> !done && rdData == '0 && rdPipe == '0 && rdSlot == '0); // R6

  AST_READ_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    done && rdAdvance && !clearAcc |=>
      (($past(rdSlot) == SLOT_W'(NUM_SLOTS - 1)) ? (rdSlot == '0)
                                                 : (rdSlot == $past(rdSlot) + 1'b1))); // R8

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rdAdvance && !clearAcc |=> $stable(rdPipe) && $stable(rdSlot)); // R8

  AST_SUMS_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    done && !rdAdvance && !clearAcc |=> $stable(rdData)); // R7
endmodule

bind pairEngine pairEngineChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .clearAcc  (clearAcc),
  .srcValid  (srcValid),
  .srcReady  (srcReady),
  .done      (done),
  .rdAdvance (rdAdvance),
  .rdPipe    (rdPipe),
  .rdSlot    (rdSlot),
  .rdData    (rdData)
);

// File: tb/pairEngine_tb.sv
module pairEngine_tb;
  import pairEnginePkg::*;

  localparam int TOTAL = NUM_PIPES * NUM_SLOTS;
  localparam int WD_CYCLES = 150000;

  typedef struct packed { int seed; int gap; } vec_t;
  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{seed: 1,    gap: 0}, '{seed: 77,   gap: 0}, '{seed: 1234, gap: 0},
    '{seed: -5,   gap: 3}, '{seed: 9001, gap: 0}, '{seed: 31,   gap: 11},
    '{seed: -400, gap: 0}, '{seed: 65535, gap: 1}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              clearAcc = 1'b0;
  logic              tgtWrEn = 1'b0;
  logic [PIPE_W-1:0] tgtPipe = '0;
  logic [SLOT_W-1:0] tgtSlot = '0;
  logic [TGT_W-1:0]  tgtData = '0;
  logic              srcValid = 1'b0;
  logic              srcReady;
  logic [REC_W-1:0]  srcRecord = '0;
  logic              eosReq = 1'b0;
  logic              done;
  logic              rdAdvance = 1'b0;
  logic [PIPE_W-1:0] rdPipe;
  logic [SLOT_W-1:0] rdSlot;
  logic [ACC_W-1:0]  rdData;

  pairEngine u_dut (.*);

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  int coefM [TOTAL];
  int selM  [TOTAL];
  int expAcc [TOTAL];
  int prevAcc = -1;

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    $display("FAIL watchdog: run hung, actual=%0d cycles expected<%0d", cyc, WD_CYCLES);
    checks++; fails++;
    summary();
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [REC_W-1:0] mkRecord(int seed);
    logic [REC_W-1:0] r;
    for (int k = 0; k < NUM_WORDS; k++)
      r[k*FIELD_W +: FIELD_W] = 16'(seed * (k + 1) * 2654 + k * 40503 + (seed >>> 3));
    return r;
  endfunction

  task automatic writeTarget(int p, int s, int sel, int coef);
    @(negedge clk);
    tgtWrEn = 1'b1; tgtPipe = PIPE_W'(p); tgtSlot = SLOT_W'(s);
    tgtData = {SEL_W'(sel), 16'(coef)};
    if (p < NUM_PIPES) begin
      coefM[p*NUM_SLOTS+s] = int'(signed'(16'(coef)));
      selM[p*NUM_SLOTS+s]  = sel;
    end
    @(negedge clk);
    tgtWrEn = 1'b0;
  endtask

  task automatic sendRecord(logic [REC_W-1:0] rec, int gap, string req);
    repeat (gap) @(negedge clk);
    srcRecord = rec; srcValid = 1'b1;
    while (!srcReady) @(negedge clk);
    @(negedge clk);
    srcValid = 1'b0;
    if (gap == 0 && prevAcc >= 0) chk({req, " R3 spacing"}, cyc - prevAcc, NUM_SLOTS);
    prevAcc = cyc;
    chk("R3 ready low after accept", int'(srcReady), 0);
    for (int i = 0; i < TOTAL; i++)
      expAcc[i] += coefM[i] * int'(signed'(rec[selM[i]*FIELD_W +: FIELD_W]));
  endtask

  task automatic endStream();
    int waited;
    @(negedge clk); eosReq = 1'b1;
    @(negedge clk); eosReq = 1'b0;
    chk("R7 ready low after eos", int'(srcReady), 0);
    waited = 0;
    while (!done && waited < 40) begin @(negedge clk); waited++; end
    chk("R7 done raised", int'(done), 1);
    prevAcc = -1;
  endtask

  task automatic readAll(string req);
    for (int i = 0; i < TOTAL; i++) begin
      chk({req, " R8 order"}, int'(rdPipe) * NUM_SLOTS + int'(rdSlot), i);
      chk({req, " sum"}, int'(signed'(rdData)), expAcc[i]);
      rdAdvance = 1'b1;
      @(negedge clk);
      rdAdvance = 1'b0;
    end
    chk("R8 wrap", int'(rdPipe) * NUM_SLOTS + int'(rdSlot), 0);
  endtask

  task automatic clearAll();
    @(negedge clk); clearAcc = 1'b1;
    @(negedge clk); clearAcc = 1'b0;
    for (int i = 0; i < TOTAL; i++) expAcc[i] = 0;
  endtask

  initial begin
    for (int i = 0; i < TOTAL; i++) begin coefM[i] = 0; selM[i] = 0; expAcc[i] = 0; end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", int'(srcReady), 1);
    chk("R1 done", int'(done), 0);
    chk("R1 pointer", int'(rdPipe) * NUM_SLOTS + int'(rdSlot), 0);
    chk("R1 data", int'(rdData), 0);

    // R2 target load, varied selectors and signs
    for (int p = 0; p < NUM_PIPES; p++)
      for (int s = 0; s < NUM_SLOTS; s++)
        writeTarget(p, s, (p * 11 + s * 7) % NUM_WORDS, (p * NUM_SLOTS + s) * 1237 - 29000);
    writeTarget(6, 2, 5, 12345);  // R2 out-of-range lane, must be ignored
    writeTarget(7, 0, 9, -777);   // R2 out-of-range lane, must be ignored

    // R8 rdAdvance before done must not move the pointer
    @(negedge clk); rdAdvance = 1'b1;
    @(negedge clk); rdAdvance = 1'b0;
    chk("R8 advance ignored before done", int'(rdPipe) * NUM_SLOTS + int'(rdSlot), 0);

    // R3 R4 R5 R10 table-driven stream
    for (int v = 0; v < NVEC; v++) sendRecord(mkRecord(VECS[v].seed), VECS[v].gap, "R4");
    endStream();
    readAll("R4 R5 R10 R2");

    // R7 records offered after done are refused
    @(negedge clk); srcRecord = mkRecord(42); srcValid = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 refused after done", int'(srcReady), 0);
    srcValid = 1'b0;
    readAll("R7 sums unchanged");

    // R6 clear
    clearAll();
    chk("R6 done dropped", int'(done), 0);
    chk("R6 ready back", int'(srcReady), 1);
    chk("R6 data zero", int'(rdData), 0);
    endStream();
    readAll("R6 all zero");

    // R9 wraparound: 3 x (-32768 * -32768) = 3 * 2^30 wraps
    clearAll();
    for (int p = 0; p < NUM_PIPES; p++)
      for (int s = 0; s < NUM_SLOTS; s++)
        writeTarget(p, s, (p + s) % NUM_WORDS, -32768);
    for (int n = 0; n < 3; n++) sendRecord({NUM_WORDS{16'h8000}}, 0, "R9");
    endStream();
    chk("R9 wrapped value", int'(signed'(rdData)), -1073741824);
    readAll("R9");

    summary();
  end
endmodule